// File: doc/BRIEF.md
# Bidirectional Dual-Port Mailbox Memory

This block passes bytes between two independent processors. Each processor owns one access port. A port has an address, an active-low chip select, an active-low write enable, an active-low output enable, a write data bus and a read data bus. The storage is two one-way areas of equal size, and the top address bit of each port picks the area. The low area carries bytes from port A to port B. The high area carries bytes from port B to port A.

A processor writes its outgoing area and reads its incoming area. The hardware suppresses any access in the wrong direction. A write in the wrong direction leaves the memory untouched. A read in the wrong direction still drives the bus, but with all zeros.

The model is synchronous. Both ports are sampled on one shared clock, and each port's read path has one register stage. The tri-state pins are replaced by a plain read bus together with a per-port drive flag. When the flag is low, the read bus is held at zero.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: With ADDR_W=8, address bit 7 selects the area on each port: 0 is the low area (A to B) and 1 is the high area (B to A). Bits 6..0 index one of 128 bytes in that area.
- R2: Port A writes the low area when a_cs_n=0, a_we_n=0 and a_addr[7]=0, for either level of a_oe_n. Port B reads that byte back with b_addr[7]=0.
- R3: Port B writes the high area when b_cs_n=0, b_we_n=0 and b_addr[7]=1, for either level of b_oe_n. Port A reads that byte back with a_addr[7]=1.
- R4: A write with the disallowed bit-7 value leaves both areas unchanged. The disallowed value is a_addr[7]=1 for port A and b_addr[7]=0 for port B.
- R5: A read strobe with the disallowed bit-7 value drives zeros with the drive flag set. The disallowed value is a_addr[7]=0 for port A and b_addr[7]=1 for port B.
- R6: A read is sampled at a rising edge when cs_n=0, we_n=1 and oe_n=0. After that same edge, the port shows the data and raises its drive flag. That state lasts until the next edge.
- R7: While cs_n=1, the port performs no write. After the edge its drive flag is 0 and its read bus is 0.
- R8: While oe_n=1, or during a write, the port's drive flag is 0 and its read bus is 0 after the edge.
- R9: Both ports work in the same cycle without affecting each other.
- R10: A read of a byte in the same cycle as the other port writes that byte returns the old contents. The next read returns the new contents.
- R11: During and right after reset, both drive flags and both read buses are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared sampling clock |
| rst_n | input | 1 | Active-low reset of the read registers |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A address; top bit picks the area |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not driven |
| a_rdata_oe | output | 1 | Port A drive flag (tri-state stand-in) |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B address; top bit picks the area |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not driven |
| b_rdata_oe | output | 1 | Port B drive flag (tri-state stand-in) |

## Verification
The hardest case to reach from the ports is the same-cycle collision: one port writes a byte on the very edge where the other port reads it. The read must return the value from before that edge. The bench sets this up directly. It drives a write on one port and a read of the same index on the other port in one call of its step task. It then reads the same index again on the next step, so the old value and the new value are both observed. Blocked writes are hard to see because they leave no mark on the outputs. So after a full sweep of wrong-direction writes, the bench reads back every byte of both areas and compares each against its own model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
  } mbx_strobe_t;

  // Write strobe: selected and write enable low; output enable plays no part.
  function automatic logic strobe_is_write(mbx_strobe_t s);
    return !s.cs_n && !s.we_n;
  endfunction

  // Read strobe: selected, write enable high, output enable low.
  function automatic logic strobe_is_read(mbx_strobe_t s);
    return !s.cs_n && s.we_n && !s.oe_n;
  endfunction

  // A port may write only the area whose select bit equals its write side.
  function automatic logic area_may_write(logic area_bit, logic write_side);
    return area_bit == write_side;
  endfunction

  // A port reads only the area opposite to the one it writes.
  function automatic logic area_may_read(logic area_bit, logic write_side);
    return area_bit != write_side;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int  ADDR_W     = 8,
  parameter bit  WRITE_SIDE = 1'b0,
  localparam int IDX_W      = ADDR_W - 1
) (
  input  mbx_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_try,
  output logic              wr_en,
  output logic              rd_req,
  output logic              rd_en,
  output logic [IDX_W-1:0]  idx
);

  logic area_bit;

  assign area_bit = addr[ADDR_W-1];
  assign idx      = addr[IDX_W-1:0];
  assign wr_try   = strobe_is_write(strobe);
  assign rd_req   = strobe_is_read(strobe);
  assign wr_en    = wr_try && area_may_write(area_bit, WRITE_SIDE);
  assign rd_en    = rd_req && area_may_read(area_bit, WRITE_SIDE);

endmodule

// File: rtl/mbx_area_ram.sv
module mbx_area_ram #(
  parameter int  DATA_W = 8,
  parameter int  IDX_W  = 7,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage has no reset; the sender fills it before the receiver reads.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // Nonblocking update: a same-edge read sees the contents before the write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_idx];
    else            rd_q <= '0;
  end

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] area_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_oe <= 1'b0;
    else        rdata_oe <= rd_req;
  end

  assign rdata = rdata_oe ? area_q : '0;

  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rdata_oe); // R6
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0)); // R8

endmodule

// File: rtl/mbx_dual_mailbox.sv
module mbx_dual_mailbox
  import mbx_pkg::*;
#(
  parameter int  DATA_W = 8,
  parameter int  ADDR_W = 8,
  localparam int IDX_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rdata_oe,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rdata_oe
);

  mbx_strobe_t a_strobe, b_strobe;
  logic a_wr_try, a_wr_en, a_rd_req, a_rd_en;
  logic b_wr_try, b_wr_en, b_rd_req, b_rd_en;
  logic a_wr_blocked, b_wr_blocked;
  logic [IDX_W-1:0]  a_idx, b_idx;
  logic [DATA_W-1:0] lo_q, hi_q;

  assign a_strobe = '{cs_n: a_cs_n, we_n: a_we_n, oe_n: a_oe_n};
  assign b_strobe = '{cs_n: b_cs_n, we_n: b_we_n, oe_n: b_oe_n};

  // Port A writes the low area (bit 0); port B writes the high area (bit 1).
  mbx_port_decode #(.ADDR_W(ADDR_W), .WRITE_SIDE(1'b0)) u_dec_a (
    .strobe(a_strobe), .addr(a_addr), .wr_try(a_wr_try), .wr_en(a_wr_en),
    .rd_req(a_rd_req), .rd_en(a_rd_en), .idx(a_idx)
  );

  mbx_port_decode #(.ADDR_W(ADDR_W), .WRITE_SIDE(1'b1)) u_dec_b (
    .strobe(b_strobe), .addr(b_addr), .wr_try(b_wr_try), .wr_en(b_wr_en),
    .rd_req(b_rd_req), .rd_en(b_rd_en), .idx(b_idx)
  );

  assign a_wr_blocked = a_wr_try && !a_wr_en;
  assign b_wr_blocked = b_wr_try && !b_wr_en;

  // Low area: written by A, read by B.
  mbx_area_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_area_lo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(a_wr_en), .wr_idx(a_idx), .wr_data(a_wdata),
    .rd_en(b_rd_en), .rd_idx(b_idx), .rd_q(lo_q)
  );

  // High area: written by B, read by A.
  mbx_area_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_area_hi (
    .clk(clk), .rst_n(rst_n),
    .wr_en(b_wr_en), .wr_idx(b_idx), .wr_data(b_wdata),
    .rd_en(a_rd_en), .rd_idx(a_idx), .rd_q(hi_q)
  );

  mbx_read_port #(.DATA_W(DATA_W)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .rd_req(a_rd_req), .area_q(hi_q),
    .rdata(a_rdata), .rdata_oe(a_rdata_oe)
  );

  mbx_read_port #(.DATA_W(DATA_W)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .rd_req(b_rd_req), .area_q(lo_q),
    .rdata(b_rdata), .rdata_oe(b_rdata_oe)
  );

  AST_A_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    a_cs_n |=> (!a_rdata_oe && a_rdata == '0)); // R7
  AST_B_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    b_cs_n |=> (!b_rdata_oe && b_rdata == '0)); // R7
  AST_A_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && (!a_we_n || a_oe_n)) |=> !a_rdata_oe); // R8
  AST_B_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && (!b_we_n || b_oe_n)) |=> !b_rdata_oe); // R8
  AST_A_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && a_we_n && !a_oe_n) |=> a_rdata_oe); // R6
  AST_B_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && b_we_n && !b_oe_n) |=> b_rdata_oe); // R6
  AST_A_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && a_we_n && !a_oe_n && !a_addr[ADDR_W-1]) |=> (a_rdata == '0)); // R5
  AST_B_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && b_we_n && !b_oe_n && b_addr[ADDR_W-1]) |=> (b_rdata == '0)); // R5
  AST_A_BLOCKED_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_blocked |-> a_addr[ADDR_W-1]); // R4
  AST_B_BLOCKED_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_blocked |-> !b_addr[ADDR_W-1]); // R4

endmodule

// File: tb/mbx_dual_mailbox_tb.sv
module mbx_dual_mailbox_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic b_cs_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [7:0] a_addr = '0, a_wdata = '0, b_addr = '0, b_wdata = '0;
  logic [7:0] a_rdata, b_rdata;
  logic a_rdata_oe, b_rdata_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] ref_lo [128];
  logic [7:0] ref_hi [128];

  always #4 clk = ~clk;

  mbx_dual_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rdata_oe(a_rdata_oe),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rdata_oe(b_rdata_oe)
  );

  task automatic chk(input string tag, input string port, input logic [7:0] d,
                     input logic oe, input logic [7:0] ed, input logic eoe);
    checks++;
    if (d !== ed || oe !== eoe) begin
      errors++;
      $display("FAIL %s port %s: data=%h oe=%b expected data=%h oe=%b",
               tag, port, d, oe, ed, eoe);
    end
  endtask

  // One cycle on both ports; the expected result comes from the model before
  // this cycle's writes are applied (read-before-write).
  task automatic step(input logic acs, input logic awe, input logic aoe,
                      input logic [7:0] aad, input logic [7:0] ad,
                      input logic bcs, input logic bwe, input logic boe,
                      input logic [7:0] bad, input logic [7:0] bd,
                      input string tag);
    logic ard, brd;
    logic [7:0] ea, eb;
    ard = !acs && awe && !aoe;
    brd = !bcs && bwe && !boe;
    ea  = (ard && aad[7])  ? ref_hi[aad[6:0]] : 8'h00;
    eb  = (brd && !bad[7]) ? ref_lo[bad[6:0]] : 8'h00;
    a_cs_n = acs; a_we_n = awe; a_oe_n = aoe; a_addr = aad; a_wdata = ad;
    b_cs_n = bcs; b_we_n = bwe; b_oe_n = boe; b_addr = bad; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "A", a_rdata, a_rdata_oe, ea, ard);
    chk(tag, "B", b_rdata, b_rdata_oe, eb, brd);
    if (!acs && !awe && !aad[7]) ref_lo[aad[6:0]] = ad;
    if (!bcs && !bwe && bad[7])  ref_hi[bad[6:0]] = bd;
  endtask

  task automatic idle(input string tag);
    step(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, tag);
  endtask

  // Full readback of both areas, A scanning up while B scans down.
  task automatic sweep_read(input string tag);
    for (int i = 0; i < 128; i++)
      step(1'b0, 1'b1, 1'b0, 8'h80 | 8'(i), 8'h00,
           1'b0, 1'b1, 1'b0, 8'(127 - i), 8'h00, tag);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "A", a_rdata, a_rdata_oe, 8'h00, 1'b0);
    chk("R11", "B", b_rdata, b_rdata_oe, 8'h00, 1'b0);
    rst_n = 1'b1;
    idle("R11");

    // R2 R3 R9: both ports fill their outgoing areas concurrently, oe toggling.
    for (int i = 0; i < 128; i++)
      step(1'b0, 1'b0, i[0], 8'(i), 8'((i * 37 + 11) & 8'hff),
           1'b0, 1'b0, ~i[0], 8'h80 | 8'(i), 8'((i * 91 + 3) ^ 8'h5a), "R2_R3");
    sweep_read("R1_R9");

    // R4: wrong-direction writes on every index, then full readback.
    for (int i = 0; i < 128; i++)
      step(1'b0, 1'b0, 1'b1, 8'h80 | 8'(i), 8'(~i),
           1'b0, 1'b0, 1'b0, 8'(i), 8'(i ^ 8'hc3), "R4");
    sweep_read("R4");

    // R5: wrong-direction reads return zeros with drive set.
    for (int i = 0; i < 128; i += 9)
      step(1'b0, 1'b1, 1'b0, 8'(i), 8'h00, 1'b0, 1'b1, 1'b0, 8'h80 | 8'(i), 8'h00, "R5");

    // R7: deselected ports with write and read strobes low do nothing.
    for (int i = 0; i < 128; i += 16) begin
      step(1'b1, 1'b0, 1'b0, 8'(i), 8'hee, 1'b1, 1'b0, 1'b0, 8'h80 | 8'(i), 8'hdd, "R7");
      step(1'b1, 1'b1, 1'b0, 8'h80 | 8'(i), 8'h00, 1'b1, 1'b1, 1'b0, 8'(i), 8'h00, "R7");
    end
    // R8: output enable high on a read strobe releases the bus.
    step(1'b0, 1'b1, 1'b1, 8'h85, 8'h00, 1'b0, 1'b1, 1'b1, 8'h05, 8'h00, "R8");
    // R6: a read followed by idle drops the drive flag after one cycle.
    step(1'b0, 1'b1, 1'b0, 8'h81, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01, 8'h00, "R6");
    idle("R6");
    sweep_read("R7_R8");

    // R10: same-edge write and read of one index, then read again.
    step(1'b0, 1'b0, 1'b1, 8'h05, 8'ha5, 1'b0, 1'b1, 1'b0, 8'h05, 8'h00, "R10");
    step(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h05, 8'h00, "R10");
    step(1'b0, 1'b1, 1'b0, 8'h89, 8'h00, 1'b0, 1'b0, 1'b0, 8'h89, 8'h3c, "R10");
    step(1'b0, 1'b1, 1'b0, 8'h89, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, "R10");
    // R9: one port writes while the other idles, and vice versa.
    step(1'b0, 1'b0, 1'b0, 8'h7f, 8'h77, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, "R9");
    step(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h7f, 8'h00, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule